// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block sits on the host side of a serial ADC link and runs one complete conversion each time it is asked. A one-cycle start request in idle makes it pull chip select low and clock three full-duplex bytes over an SPI mode 0 link. The first byte it sends is a control word that puts the converter in external-clock mode on the selected channel and mode. The next two bytes are zero, and they only clock the answer out. Whatever arrives during the first byte is discarded. After the third byte, chip select is released and the 10-bit sample is taken from the padded 16-bit word formed by the second and third received bytes.

The serial clock comes from the system clock through a divider whose half-period length is set per conversion. An optional idle gap can be placed between bytes. A watchdog counts the system cycles spent in each conversion and raises a sticky error flag when the count goes past a fixed limit. The default limit is 120 µs at 125 MHz. Busy stays high from the accepted request until chip select rises. In that same cycle, done pulses and the new result appears.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, busy is 0, done is 0, timeout is 0 and result is 0.
- R2: A start sampled high while idle is accepted. From the next cycle, cs_n is 0 and busy is 1, and both hold for all three bytes with no release between them. In the cycle after the edge that ends the last high phase of the 24th SCLK pulse, cs_n returns to 1 and busy returns to 0.
- R3: SCLK idles low. Each bit is a low phase of H system cycles followed by a high phase of H cycles. H equals half_div, and a half_div of 0 is treated as 1. Each byte has eight pulses.
- R4: The first byte sent on mosi is 1, then chan_mode[4] down to chan_mode[0], then 1, 1, most significant bit first. The second and third bytes are all zeros. mosi changes only where SCLK falls or when a frame starts, and it stays 0 while idle.
- R5: miso is sampled at the end of each low phase, which is the rising SCLK edge. The 8 bits of the first byte are discarded. Take the 16 bits of bytes two and three, with the first bit received as bit 15. result is bits 14 down to 5 of that word, so the leading bit and the five trailing bits have no effect.
- R6: When gap_len is G > 0, SCLK stays low and cs_n stays low for G system cycles between byte one and byte two, and again between byte two and byte three. There is no gap after the last byte. A frame therefore lasts 48·H + 2·G cycles.
- R7: done is high for exactly one cycle, the cycle in which cs_n rises. result takes its new value in that cycle and holds it until the next done.
- R8: A start request while busy is ignored. chan_mode, half_div and gap_len are captured when a request is accepted, and later changes do not affect that frame.
- R9: If busy is still high in system cycle TIMEOUT_CYC after acceptance (cycle 0 is the first busy cycle), timeout goes high one cycle later. It then stays high until the next accepted start clears it. The frame still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, sampled while idle |
| chan_mode | input | 5 | Channel and mode bits placed in the control byte |
| half_div | input | DIV_W | System cycles per SCLK half period (0 acts as 1) |
| gap_len | input | GAP_W | Idle system cycles between bytes |
| miso | input | 1 | Serial data from the ADC |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the ADC |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | 10 | Extracted conversion result |
| timeout | output | 1 | Sticky conversion-time error flag |

## Verification
A miscounted bit or byte index shows up within one SCLK half period. It appears as an extra or missing SCLK pulse, a control bit out of place on mosi, or a cs_n release that comes too early or too late. These are all visible in the per-cycle comparison of the pins against a model that knows only the frame timing. A receive register aligned wrongly goes unseen until done, where result differs from the value planted in the padded word. That word carries nonzero leading and trailing padding, so a one-position shift is caught. A watchdog counter that is off by one is exposed by one frame that ends exactly at the limit and one that goes just past it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int BYTE_BITS   = 8;
    localparam int FRAME_BYTES = 3;
    localparam int CMODE_W     = 5;
    localparam int RES_W       = 10;
    localparam int RES_LSB     = 5;
    localparam int RX_W        = RES_LSB + RES_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_GAP  = 2'd3
    } seq_st_e;

    function automatic logic [BYTE_BITS-1:0] ctrl_byte(input logic [CMODE_W-1:0] cm);
        return {1'b1, cm, 2'b11};
    endfunction

endpackage

// File: rtl/adc_seq_cnt.sv
module adc_seq_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] lim_m1,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == lim_m1);
        cnt_d = cnt_q;
        if (en) begin
            cnt_d = tick ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_seq_wdog.sv
module adc_seq_wdog #(
    parameter int LIMIT = 15000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic flag
);
    localparam int TO_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [TO_W-1:0] cnt;
        logic            flag;
    } wd_t;

    wd_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d.cnt  = '0;
            d.flag = 1'b0;
        end else if (run) begin
            if (q.cnt == TO_W'(LIMIT)) d.flag = 1'b1;
            else                        d.cnt  = q.cnt + TO_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag = q.flag;

    AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !clr) |=> q.flag); // R9
    AST_TO_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> (q.cnt == TO_W'(LIMIT))); // R9
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV_W       = 10,
    parameter int GAP_W       = 8,
    parameter int TIMEOUT_CYC = 15000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [4:0]       chan_mode,
    input  logic [DIV_W-1:0] half_div,
    input  logic [GAP_W-1:0] gap_len,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    output logic             busy,
    output logic             done,
    output logic [9:0]       result,
    output logic             timeout
);
    localparam int BIT_W  = $clog2(BYTE_BITS);
    localparam int BYTE_W = $clog2(FRAME_BYTES);

    typedef struct packed {
        seq_st_e                st;
        logic                   cs_n;
        logic                   sclk;
        logic                   busy;
        logic                   done;
        logic [BYTE_BITS-1:0]   tx;
        logic [RX_W-1:0]        rx;
        logic [BIT_W-1:0]       bit_idx;
        logic [BYTE_W-1:0]      byte_idx;
        logic [DIV_W-1:0]       half_m1;
        logic [GAP_W-1:0]       gap;
        logic [RES_W-1:0]       result;
    } seq_t;

    seq_t d, q;
    logic half_tick, gap_tick, accept;

    adc_seq_cnt #(.W(DIV_W)) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (q.st == ST_LOW || q.st == ST_HIGH),
        .lim_m1 (q.half_m1),
        .tick   (half_tick)
    );

    adc_seq_cnt #(.W(GAP_W)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (q.st == ST_GAP),
        .lim_m1 (q.gap - GAP_W'(1)),
        .tick   (gap_tick)
    );

    assign accept = (q.st == ST_IDLE) && start;

    adc_seq_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .run   (q.busy),
        .flag  (timeout)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st       = ST_LOW;
                    d.cs_n     = 1'b0;
                    d.busy     = 1'b1;
                    d.tx       = ctrl_byte(chan_mode);
                    d.bit_idx  = '0;
                    d.byte_idx = '0;
                    d.half_m1  = (half_div == '0) ? '0 : half_div - DIV_W'(1);
                    d.gap      = gap_len;
                end
            end
            ST_LOW: begin
                if (half_tick) begin
                    d.sclk = 1'b1;
                    d.rx   = {q.rx[RX_W-2:0], miso};
                    d.st   = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (half_tick) begin
                    d.sclk = 1'b0;
                    if (q.bit_idx == BIT_W'(BYTE_BITS - 1)) begin
                        d.bit_idx = '0;
                        d.tx      = '0;
                        if (q.byte_idx == BYTE_W'(FRAME_BYTES - 1)) begin
                            d.st     = ST_IDLE;
                            d.cs_n   = 1'b1;
                            d.busy   = 1'b0;
                            d.done   = 1'b1;
                            d.result = q.rx[RX_W-1:RES_LSB];
                        end else begin
                            d.byte_idx = q.byte_idx + BYTE_W'(1);
                            d.st       = (q.gap != '0) ? ST_GAP : ST_LOW;
                        end
                    end else begin
                        d.bit_idx = q.bit_idx + BIT_W'(1);
                        d.tx      = {q.tx[BYTE_BITS-2:0], 1'b0};
                        d.st      = ST_LOW;
                    end
                end
            end
            ST_GAP: begin
                if (gap_tick) d.st = ST_LOW;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk   = q.sclk;
    assign mosi   = q.tx[BYTE_BITS-1];
    assign cs_n   = q.cs_n;
    assign busy   = q.busy;
    assign done   = q.done;
    assign result = q.result;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> !q.sclk); // R3
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        q.sclk |-> $stable(q.tx[BYTE_BITS-1])); // R4
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!q.cs_n && q.busy)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R7
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cs_n) |-> q.done); // R7
    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP) |-> (!q.sclk && !q.cs_n)); // R6
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !(q.st == ST_HIGH && half_tick)) |=> q.busy); // R8
endmodule

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;
    localparam int LIMIT = 15000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] chan_mode = '0;
    logic [9:0] half_div = '0;
    logic [7:0] gap_len = '0;
    logic       miso = 1'b0;
    logic       sclk, mosi, cs_n, busy, done, timeout;
    logic [9:0] result;

    adc_conv_seq #(.DIV_W(10), .GAP_W(8), .TIMEOUT_CYC(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_mode(chan_mode),
        .half_div(half_div), .gap_len(gap_len), .miso(miso),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done),
        .result(result), .timeout(timeout)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
        end
    endtask

    // behavioural reference model
    logic [23:0] pat = '0;
    logic [23:0] cur_pat = '0;
    logic [7:0]  m_ctrl = '0;
    int  H = 1, G = 0, T = 48, t = 0;
    bit  act = 0, was_act = 0, m_done = 0, m_to = 0;
    logic [9:0] m_res = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            act = 0; t = 0; m_done = 0; m_to = 0; m_res = '0;
        end else begin
            was_act = act;
            m_done = 0;
            if (was_act) begin
                if (t == LIMIT) m_to = 1;
                t = t + 1;
                if (t == T) begin
                    act = 0;
                    m_done = 1;
                    m_res = cur_pat[14:5];
                end
            end else if (start) begin
                act = 1; t = 0;
                H = (half_div == 0) ? 1 : int'(half_div);
                G = int'(gap_len);
                T = 48 * H + 2 * G;
                m_ctrl = {1'b1, chan_mode, 2'b11};
                cur_pat = pat;
                m_to = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            miso = 1'b0;
        end else if (!finished) begin
            int u, b, i;
            bit ingap, e_sclk, e_mosi, e_miso;
            u = t; b = 0; ingap = 0; e_sclk = 0; e_mosi = 0; e_miso = 0;
            if (act) begin
                if (u >= 16 * H) begin
                    u -= 16 * H;
                    if (u < G) ingap = 1;
                    else begin
                        u -= G;
                        b = 1;
                        if (u >= 16 * H) begin
                            u -= 16 * H;
                            if (u < G) ingap = 1;
                            else begin u -= G; b = 2; end
                        end
                    end
                end
                if (!ingap) begin
                    i = u / (2 * H);
                    e_sclk = (u % (2 * H)) >= H;
                    e_mosi = (b == 0) ? m_ctrl[7 - i] : 1'b0;
                    e_miso = cur_pat[23 - (8 * b + i)];
                end
            end
            chk("R2", "cs_n", int'(cs_n), act ? 0 : 1);
            chk("R2", "busy", int'(busy), act ? 1 : 0);
            chk(ingap ? "R6" : "R3", "sclk", int'(sclk), int'(e_sclk));
            chk("R4", "mosi", int'(mosi), int'(e_mosi));
            chk("R7", "done", int'(done), act ? 0 : int'(m_done));
            chk("R5", "result", int'(result), int'(m_res));
            chk("R9", "timeout", int'(timeout), int'(m_to));
            miso = e_miso;
        end
    end

    task automatic run(input logic [4:0] cm, input int h, input int g,
                       input logic [9:0] val, input logic [7:0] junk,
                       input logic [5:0] pad, input bit poke);
        @(negedge clk);
        chan_mode = cm; half_div = 10'(h); gap_len = 8'(g);
        pat = {junk, pad[5], val, pad[4:0]};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            chan_mode = ~cm; half_div = 10'(h + 2); gap_len = 8'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R8", "busy after start while busy", int'(busy), 1);
        end
        while (!done) @(negedge clk);
        chk("R5", "extracted result", int'(result), int'(val));
        chk("R7", "cs_n high at done", int'(cs_n), 1);
        @(negedge clk);
        chk("R7", "done cleared", int'(done), 0);
        chk("R7", "result held", int'(result), int'(val));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "cs_n", int'(cs_n), 1);
        chk("R1", "sclk", int'(sclk), 0);
        chk("R1", "mosi", int'(mosi), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "timeout", int'(timeout), 0);
        chk("R1", "result", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(5'b10110, 1, 0, 10'h2A5, 8'hFF, 6'b100101, 0);
        run(5'b01001, 3, 5, 10'h15A, 8'hA5, 6'b011010, 0);
        run(5'b00000, 0, 1, 10'h3FF, 8'h3C, 6'b000000, 0);
        run(5'b11111, 2, 0, 10'h001, 8'h81, 6'b111111, 1);
        run(5'b10001, 312, 12, 10'h200, 8'h00, 6'b000001, 0);
        chk("R9", "no timeout at exact limit", int'(timeout), 0);
        run(5'b01110, 313, 0, 10'h133, 8'h5A, 6'b100000, 0);
        repeat (5) @(negedge clk);
        chk("R9", "timeout sticky after overrun", int'(timeout), 1);
        run(5'b00101, 1, 2, 10'h0C3, 8'h11, 6'b010101, 0);
        chk("R9", "timeout cleared by new start", int'(timeout), 0);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule